// File: doc/BRIEF.md
# Chained Descriptor Ring Walker

This block is the device-side sequencer for one direction of a DMA descriptor ring. Host software builds a ring of four-word descriptors in memory. Each descriptor is linked to the next one by an address stored inside it, and the last descriptor links back to the first. The walker reads each descriptor through a single-request memory port. It hands the buffer address and length to a separate data engine through a request/done handshake, then returns the descriptor to the host by writing the status word with the ownership flag cleared.

A run input starts and stops the walker. A poll strobe wakes it after it has found a descriptor that the host still holds. The ring base address is taken only while the walker is stopped. A three-bit state output shows whether the walker is stopped, fetching, waiting on the data engine, writing back, or suspended.

Descriptor layout, in bytes from the descriptor address: +0 holds the status word, with bit 31 as the ownership flag (1 means the device owns it) and bits 15:0 as completion status. +4 holds the control word, with bit 30 marking the last segment and bits 10:0 giving the buffer size. +8 holds the buffer address and +12 holds the next-descriptor address.

Top module: `desc_ring_walker`

## Requirements
- R1: After reset, state_o is 0 (stopped), and mem_req and dat_req are low.
- R2: When processing a descriptor at address D, the walker reads D, D+4, D+8 and D+12 in that order. It reads only these four words and skips the rest of the descriptor if bit 31 of the word at D is 0.
- R3: If the status word read at D has bit 31 equal to 0, the walker enters state 4 (suspended) and issues no memory request. A poll pulse while run is high then re-reads the word at the same address D.
- R4: When a descriptor has a non-zero size, dat_req rises with dat_addr equal to word +8, dat_len equal to word +4 bits 10:0, and dat_last equal to word +4 bit 30. dat_req stays high until dat_done.
- R5: When the size field is zero, no data request is made and the walker goes directly to write-back.
- R6: Each descriptor gets exactly one write, to address D, after dat_done (or after the fetch when the size is zero). The written word has bit 31 = 0 and bits 30:16 = 0. Bits 15:0 hold dat_status when the last-segment bit is set and the size is non-zero; otherwise they are 0.
- R7: The next descriptor processed is the one at the address read from word +12, so the walk follows the chain and wraps around the ring.
- R8: A base_wr pulse loads base_addr only when state_o is 0; pulses in any other state are ignored. Each start from the stopped state begins at the loaded base.
- R9: When run is cleared, the walker finishes the descriptor in progress, including its write-back, and then reports state 0. From the suspended state it stops on the next cycle.
- R10: mem_req, mem_addr and mem_we stay unchanged while a memory access waits for mem_ack. state_o encodes 0 stopped, 1 fetching, 2 data transfer, 3 write-back and 4 suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Walker enable |
| poll | input | 1 | Retry strobe for a suspended walker |
| base_wr | input | 1 | Load strobe for the ring base |
| base_addr | input | AW | Ring base address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Read data |
| dat_req | output | 1 | Buffer transfer request |
| dat_addr | output | AW | Buffer address |
| dat_len | output | LW | Buffer size |
| dat_last | output | 1 | Descriptor is the last segment |
| dat_done | input | 1 | Buffer transfer finished |
| dat_status | input | SW | Completion status from the data engine |
| state_o | output | 3 | Walker state |

## Verification
The hardest situations to reach are the ones at the edge of a descriptor's lifecycle. One is a stop request that arrives while a transfer is in flight. Another is a base write issued while the walker runs, whose effect shows only at the next start. A third is a re-poll after suspension, which must revisit the exact descriptor the walker gave up on. A dedicated sequence covers these. It lowers run at the first observed data request, pulses base_wr while fetching, and restarts to check that the walk begins at the old base. It then rewrites ownership flags in memory before pulsing poll. Around this, a sweep of twelve rings covers data-engine latency, last-segment flags and zero sizes, with the rings placed at chained slots that differ from round to round.

// File: rtl/ring_pkg.sv
package ring_pkg;
  typedef enum logic [2:0] {
    ST_STOP  = 3'd0,
    ST_FETCH = 3'd1,
    ST_DATA  = 3'd2,
    ST_WBACK = 3'd3,
    ST_SUSP  = 3'd4
  } walk_state_t;

  localparam int OWN_BIT    = 31;
  localparam int LAST_BIT   = 30;
  localparam int DESC_WORDS = 4;
endpackage

// File: rtl/ring_base_reg.sv
module ring_base_reg #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          stopped,
  output logic [AW-1:0] base
);
  always_ff @(posedge clk) begin
    if (rst)                  base <= '0;
    else if (wr_en && stopped) base <= wr_addr;
  end

  a_r8_base_frozen: assert property (@(posedge clk) disable iff (rst)
    !stopped |=> $stable(base));
endmodule

// File: rtl/ring_desc_store.sv
module ring_desc_store #(
  parameter int AW = 32,
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_en,
  input  logic [1:0]    cap_idx,
  input  logic [31:0]   cap_data,
  output logic [AW-1:0] buf_addr,
  output logic [AW-1:0] nxt_addr,
  output logic [LW-1:0] buf_len,
  output logic          seg_last
);
  import ring_pkg::*;

  logic [31:0] words [DESC_WORDS];

  for (genvar g = 0; g < DESC_WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)                                   words[g] <= '0;
      else if (cap_en && cap_idx == 2'(g))       words[g] <= cap_data;
    end
  end

  assign buf_len  = words[1][LW-1:0];
  assign seg_last = words[1][LAST_BIT];
  assign buf_addr = words[2][AW-1:0];
  assign nxt_addr = words[3][AW-1:0];
endmodule

// File: rtl/ring_ctrl.sv
module ring_ctrl #(
  parameter int AW = 32,
  parameter int LW = 11,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          poll,
  input  logic [AW-1:0] base,
  input  logic [LW-1:0] buf_len,
  input  logic          seg_last,
  input  logic [AW-1:0] nxt_addr,
  input  logic          mem_ack,
  input  logic          rd_own,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic          cap_en,
  output logic [1:0]    cap_idx,
  output logic          dat_req,
  input  logic          dat_done,
  input  logic [SW-1:0] dat_status,
  output logic [2:0]    state_o
);
  import ring_pkg::*;

  localparam int PADW = 31 - SW;

  walk_state_t   st;
  logic [1:0]    widx;
  logic [1:0]    widx_n;
  logic [AW-1:0] cur;
  logic          len_zero;

  assign widx_n   = widx + 2'd1;
  assign len_zero = (buf_len == '0);
  assign cap_en   = (st == ST_FETCH) && mem_ack;
  assign cap_idx  = widx;
  assign state_o  = st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_STOP;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      widx      <= '0;
      cur       <= '0;
      dat_req   <= 1'b0;
    end else begin
      case (st)
        ST_STOP: begin
          if (run) begin
            st       <= ST_FETCH;
            cur      <= base;
            mem_addr <= base;
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            widx     <= '0;
          end
        end
        ST_FETCH: begin
          if (mem_ack) begin
            if (widx == 2'd0 && !rd_own) begin
              mem_req <= 1'b0;
              st      <= ST_SUSP;
            end else if (widx == 2'd3) begin
              if (len_zero) begin
                st        <= ST_WBACK;
                mem_we    <= 1'b1;
                mem_addr  <= cur;
                mem_wdata <= '0;
              end else begin
                mem_req <= 1'b0;
                st      <= ST_DATA;
                dat_req <= 1'b1;
              end
            end else begin
              widx     <= widx_n;
              mem_addr <= cur + {{(AW-4){1'b0}}, widx_n, 2'b00};
            end
          end
        end
        ST_DATA: begin
          if (dat_done) begin
            dat_req   <= 1'b0;
            st        <= ST_WBACK;
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= cur;
            mem_wdata <= {1'b0, {PADW{1'b0}}, seg_last ? dat_status : {SW{1'b0}}};
          end
        end
        ST_WBACK: begin
          if (mem_ack) begin
            mem_we <= 1'b0;
            cur    <= nxt_addr;
            widx   <= '0;
            if (run) begin
              st       <= ST_FETCH;
              mem_req  <= 1'b1;
              mem_addr <= nxt_addr;
            end else begin
              st      <= ST_STOP;
              mem_req <= 1'b0;
            end
          end
        end
        ST_SUSP: begin
          if (!run) begin
            st <= ST_STOP;
          end else if (poll) begin
            st       <= ST_FETCH;
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= cur;
            widx     <= '0;
          end
        end
        default: st <= ST_STOP;
      endcase
    end
  end

  a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  a_r6_own_cleared: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> !mem_wdata[OWN_BIT]);
  a_r6_single_write: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we && mem_ack |=> !(mem_req && mem_we));
  a_r5_no_empty_xfer: assert property (@(posedge clk) disable iff (rst)
    dat_req |-> buf_len != '0);
  a_r4_dat_hold: assert property (@(posedge clk) disable iff (rst)
    dat_req && !dat_done |=> dat_req);
  a_r3_susp_quiet: assert property (@(posedge clk) disable iff (rst)
    state_o == 3'd4 |-> !mem_req && !dat_req);
endmodule

// File: rtl/desc_ring_walker.sv
module desc_ring_walker #(
  parameter int AW = 32,
  parameter int LW = 11,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          poll,
  input  logic          base_wr,
  input  logic [AW-1:0] base_addr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          dat_req,
  output logic [AW-1:0] dat_addr,
  output logic [LW-1:0] dat_len,
  output logic          dat_last,
  input  logic          dat_done,
  input  logic [SW-1:0] dat_status,
  output logic [2:0]    state_o
);
  import ring_pkg::*;

  logic [AW-1:0] base;
  logic [AW-1:0] nxt_addr;
  logic          cap_en;
  logic [1:0]    cap_idx;
  logic          stopped;

  assign stopped = (state_o == 3'(ST_STOP));

  ring_base_reg #(.AW(AW)) u_base (
    .clk(clk), .rst(rst), .wr_en(base_wr), .wr_addr(base_addr),
    .stopped(stopped), .base(base)
  );

  ring_desc_store #(.AW(AW), .LW(LW)) u_store (
    .clk(clk), .rst(rst), .cap_en(cap_en), .cap_idx(cap_idx),
    .cap_data(mem_rdata), .buf_addr(dat_addr), .nxt_addr(nxt_addr),
    .buf_len(dat_len), .seg_last(dat_last)
  );

  ring_ctrl #(.AW(AW), .LW(LW), .SW(SW)) u_ctrl (
    .clk(clk), .rst(rst), .run(run), .poll(poll), .base(base),
    .buf_len(dat_len), .seg_last(dat_last), .nxt_addr(nxt_addr),
    .mem_ack(mem_ack), .rd_own(mem_rdata[OWN_BIT]),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .cap_en(cap_en), .cap_idx(cap_idx),
    .dat_req(dat_req), .dat_done(dat_done), .dat_status(dat_status),
    .state_o(state_o)
  );
endmodule

// File: tb/tb_desc_ring_walker.sv
module tb_desc_ring_walker;
  localparam int AW = 32;
  localparam int LW = 11;
  localparam int SW = 16;

  logic clk = 0, rst = 1, run = 0, poll = 0, base_wr = 0;
  logic [AW-1:0] base_addr = '0;
  logic mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic dat_req, dat_last, dat_done = 0;
  logic [AW-1:0] dat_addr;
  logic [LW-1:0] dat_len;
  logic [SW-1:0] dat_status = '0;
  logic [2:0] state_o;

  always #10 clk = ~clk;

  desc_ring_walker #(.AW(AW), .LW(LW), .SW(SW)) dut (
    .clk(clk), .rst(rst), .run(run), .poll(poll), .base_wr(base_wr),
    .base_addr(base_addr), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .dat_req(dat_req), .dat_addr(dat_addr),
    .dat_len(dat_len), .dat_last(dat_last), .dat_done(dat_done),
    .dat_status(dat_status), .state_o(state_o)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: one-cycle acknowledge
  logic [31:0] mem [64];
  always @(posedge clk) begin
    if (rst) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[7:2]];
      if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
    end else mem_ack <= 1'b0;
  end

  // expectations
  logic [31:0] exp_rd [64];
  logic [31:0] exp_wa [16], exp_wd [16];
  logic [31:0] exp_da [16];
  logic [LW-1:0] exp_dl [16];
  logic exp_dlast [16];
  int rd_n, wr_n, dt_n, rd_i, wr_i, dt_i;
  logic [31:0] da [4];
  logic [31:0] dw1 [4], dw2 [4];

  function automatic logic [SW-1:0] stat_of(input logic [31:0] a, input logic [LW-1:0] l);
    return a[15:0] ^ {5'd0, l} ^ 16'h3C00;
  endfunction

  // monitors and data engine
  logic p_req = 0, p_ack = 0;
  logic [31:0] p_addr = 0;
  int dcnt = 0;
  bit dseen = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (p_req && !p_ack)
        chk(mem_req && mem_addr == p_addr, "R10 hold", mem_addr, p_addr);
      p_req = mem_req; p_ack = mem_ack; p_addr = mem_addr;
      if (mem_req && mem_ack && !mem_we) begin
        if (rd_i < rd_n) chk(mem_addr == exp_rd[rd_i], "R2/R7 read addr", mem_addr, exp_rd[rd_i]);
        else chk(0, "R3 unexpected read", mem_addr, 32'hFFFFFFFF);
        rd_i++;
      end
      if (mem_req && mem_ack && mem_we) begin
        if (wr_i < wr_n) begin
          chk(mem_addr == exp_wa[wr_i], "R6 write addr", mem_addr, exp_wa[wr_i]);
          chk(mem_wdata == exp_wd[wr_i], "R6 write data", mem_wdata, exp_wd[wr_i]);
        end else chk(0, "R6 extra write", mem_addr, 32'hFFFFFFFF);
        wr_i++;
      end
      if (dat_done) begin
        dat_done = 0; dseen = 0; dcnt = 0;
      end else if (dat_req) begin
        if (!dseen) begin
          dseen = 1;
          if (dt_i < dt_n) begin
            chk(dat_addr == exp_da[dt_i], "R4 dat_addr", dat_addr, exp_da[dt_i]);
            chk(dat_len == exp_dl[dt_i], "R4/R5 dat_len", 32'(dat_len), 32'(exp_dl[dt_i]));
            chk(dat_last == exp_dlast[dt_i], "R4 dat_last", 32'(dat_last), 32'(exp_dlast[dt_i]));
          end else chk(0, "R5 unexpected data request", dat_addr, 32'hFFFFFFFF);
        end
        if (dcnt >= (dt_i * 3) % 4) begin
          dat_done = 1;
          dat_status = stat_of(dat_addr, dat_len);
          dt_i++;
        end else dcnt++;
      end
    end
  end

  task automatic clear_exp();
    rd_n = 0; wr_n = 0; dt_n = 0; rd_i = 0; wr_i = 0; dt_i = 0;
  endtask

  task automatic add_desc(input int i);
    for (int k = 0; k < 4; k++) begin exp_rd[rd_n] = da[i] + 32'(4 * k); rd_n++; end
    if (dw1[i][10:0] != 0) begin
      exp_da[dt_n] = dw2[i]; exp_dl[dt_n] = dw1[i][10:0]; exp_dlast[dt_n] = dw1[i][30]; dt_n++;
    end
    exp_wa[wr_n] = da[i];
    exp_wd[wr_n] = (dw1[i][30] && dw1[i][10:0] != 0) ? {16'd0, stat_of(dw2[i], dw1[i][10:0])} : 32'd0;
    wr_n++;
  endtask

  task automatic setup_ring(input int r);
    for (int i = 0; i < 4; i++) begin
      da[i] = 32'(((r * 5 + i * 7) % 16) * 16);
      dw1[i] = {1'b0, 1'(r + i), 19'd0, 11'((r * 131 + i * 389 + 1) % 2048)};
      if ((r % 2 == 1) && i == (r % 4)) dw1[i][10:0] = 11'd0;
      dw2[i] = 32'h1000_0000 + 32'(r * 256 + i * 16);
    end
    for (int i = 0; i < 4; i++) begin
      mem[da[i][7:2]]     = 32'h8000_5A5A;
      mem[da[i][7:2] + 1] = dw1[i];
      mem[da[i][7:2] + 2] = dw2[i];
      mem[da[i][7:2] + 3] = da[(i + 1) % 4];
    end
    base_wr = 1; base_addr = da[0];
    @(negedge clk); base_wr = 0;
  endtask

  task automatic wait_st(input logic [2:0] s, input string tag);
    int n = 0;
    while (state_o != s && n < 3000) begin @(negedge clk); n++; end
    chk(state_o == s, tag, 32'(state_o), 32'(s));
  endtask

  task automatic check_counts(input string tag);
    chk(rd_i == rd_n, {tag, " read count"}, rd_i, rd_n);
    chk(wr_i == wr_n, {tag, " write count"}, wr_i, wr_n);
    chk(dt_i == dt_n, {"R5 ", tag, " data count"}, dt_i, dt_n);
  endtask

  initial begin
    for (int w = 0; w < 64; w++) mem[w] = 32'd0;
    clear_exp();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(state_o == 3'd0, "R1 state", 32'(state_o), 0);
    chk(!mem_req && !dat_req, "R1 idle", {30'd0, mem_req, dat_req}, 0);

    // sweep of rings: R2 R4 R5 R6 R7 R3 R9
    for (int r = 0; r < 12; r++) begin
      setup_ring(r);
      clear_exp();
      for (int i = 0; i < 4; i++) add_desc(i);
      exp_rd[rd_n] = da[0]; rd_n++;
      run = 1;
      wait_st(3'd4, "R3 suspend after wrap");
      check_counts("R7 ring");
      for (int i = 0; i < 4; i++)
        chk(mem[da[i][7:2]] == exp_wd[i], "R6 memory word0", mem[da[i][7:2]], exp_wd[i]);
      repeat (3) @(negedge clk);
      chk(!mem_req && state_o == 3'd4, "R3 quiet while suspended", {28'd0, state_o, mem_req}, 4 << 1);
      run = 0;
      @(negedge clk);
      chk(state_o == 3'd0, "R9 stop from suspend", 32'(state_o), 0);
    end

    // stop mid-transfer, ignored base write, restart, poll
    setup_ring(13);
    clear_exp();
    add_desc(0);
    run = 1;
    @(negedge clk);
    base_wr = 1; base_addr = 32'h0000_00F0;
    @(negedge clk);
    base_wr = 0;
    while (!dat_req) @(negedge clk);
    run = 0;
    wait_st(3'd0, "R9 stop after current descriptor");
    check_counts("R9 stop");
    clear_exp();
    exp_rd[0] = da[0]; rd_n = 1;
    run = 1;
    wait_st(3'd4, "R8 restart from old base");
    check_counts("R8 restart");
    mem[da[0][7:2]] = 32'h8000_0000;
    mem[da[1][7:2]] = 32'h0000_0000;
    clear_exp();
    add_desc(0);
    exp_rd[rd_n] = da[1]; rd_n++;
    poll = 1;
    @(negedge clk);
    poll = 0;
    chk(state_o == 3'd1, "R3 poll resumes fetch", 32'(state_o), 1);
    wait_st(3'd4, "R3 suspend on next");
    check_counts("R3 poll");
    run = 0;
    @(negedge clk);
    // base load while stopped takes effect
    base_wr = 1; base_addr = da[1];
    @(negedge clk);
    base_wr = 0;
    clear_exp();
    exp_rd[0] = da[1]; rd_n = 1;
    run = 1;
    wait_st(3'd4, "R8 start from new base");
    check_counts("R8 new base");
    run = 0;
    @(negedge clk);
    chk(state_o == 3'd0, "R9 final stop", 32'(state_o), 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule